// File: doc/BRIEF.md
# Page-Walk Request Merging Filter

This block sits on the long path between a multi-channel first-level TLB and a distant second-level TLB. Each cycle, every request channel may present a page-table-walk miss carrying a virtual page number (VPN). The filter compares every incoming VPN against the live entries of a small table, against the other channels of the same cycle, and against a walk response arriving in that cycle. A single downstream walk therefore serves every duplicate miss. Only the first sighting of a VPN takes a table entry.

Entries that have not yet been sent are issued one at a time toward the second-level TLB over a valid-ready handshake, in the order they were taken. A walk response carries the VPN, the physical page number, permission bits, page-table level and a fault flag. It is handed straight back to the first-level TLB. The matching entry is released in the same cycle the upstream side accepts the response. When the table has no free slot, a request with a new VPN sees its channel's ready low and is dropped, and the TLB must resend it later. The table depth is therefore the limit on walks in flight at the second level.

Top module: `ptw_merge_filter`

## Requirements
- R1: After reset the table is empty: `dn_req_valid` is 0, `up_rsp_valid` follows `dn_rsp_valid` (0 when idle), and every channel's `req_ready` is 1.
- R2: A valid request whose VPN is new takes a free entry and is accepted. Pending entries are offered on `dn_req_vpn` in allocation order; within one cycle, channel 0 is allocated before channel 1.
- R3: Channels that present the same new VPN in one cycle are all accepted, and only one entry, and so only one downstream request, is created.
- R4: A request whose VPN matches a live entry, issued or not, is accepted (`req_ready` = 1) and creates no entry and no further downstream request.
- R5: While `dn_req_valid` is 1 and `dn_req_ready` is 0, the next cycle keeps `dn_req_valid` at 1 and `dn_req_vpn` unchanged.
- R6: The response path is combinational: `up_rsp_valid` = `dn_rsp_valid`, `dn_rsp_ready` = `up_rsp_ready`, and the VPN, PPN, permission, level and fault fields pass through unchanged.
- R7: An issued entry is released in the cycle its response is accepted upstream (`dn_rsp_valid` and `up_rsp_ready` high with a matching VPN). A later request for that VPN then starts a new walk.
- R8: When all entries are live, a request with a new VPN sees `req_ready` = 0, is dropped, and leaves no trace downstream. Requests that match a live entry are still accepted.
- R9: When fewer free entries exist than channels with new VPNs, the lower-numbered channels win. With one free slot and two new VPNs, `req_ready` is 2'b01.
- R10: A request whose VPN equals that of a response accepted in the same cycle is accepted and creates no entry.
- R11: Up to DEPTH walks can be pending or outstanding at once. Each accepted unique VPN is issued downstream exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NUM_CH | Per-channel miss request valid |
| req_vpn | input | NUM_CH*VPN_W | Per-channel VPN, channel c at bits [c*VPN_W +: VPN_W] |
| req_ready | output | NUM_CH | Per-channel accept; 0 only for a new VPN with no slot left |
| dn_req_valid | output | 1 | Walk request toward the second-level TLB |
| dn_req_vpn | output | VPN_W | VPN of the walk request |
| dn_req_ready | input | 1 | Second-level TLB takes the walk request |
| dn_rsp_valid | input | 1 | Walk response valid |
| dn_rsp_ready | output | 1 | Walk response taken |
| dn_rsp_vpn | input | VPN_W | VPN the response belongs to |
| dn_rsp_ppn | input | PPN_W | Physical page number |
| dn_rsp_perm | input | PERM_W | Permission bits |
| dn_rsp_level | input | LVL_W | Page-table level of the leaf |
| dn_rsp_fault | input | 1 | Walk ended in a fault |
| up_rsp_valid | output | 1 | Response valid toward the first-level TLB |
| up_rsp_ready | input | 1 | First-level TLB takes the response |
| up_rsp_vpn | output | VPN_W | Response VPN |
| up_rsp_ppn | output | PPN_W | Response physical page number |
| up_rsp_perm | output | PERM_W | Response permission bits |
| up_rsp_level | output | LVL_W | Response page-table level |
| up_rsp_fault | output | 1 | Response fault flag |

## Verification
The bench builds the filter with 2 channels, 8 entries and a 12-bit VPN, small enough that every table occupancy from empty to full can be visited. At each fill level from 0 to 8 it offers two new VPNs at once. The ready pattern and the exact downstream issue sequence follow arithmetically from the fill level, which covers the full-table drop, the lowest-channel-wins rule and in-order issue at every boundary. Directed cycles add merges against issued entries, same-cycle duplicates, a request that meets its own response, and the release and reuse of a slot.

// File: rtl/ptwf_pkg.sv
package ptwf_pkg;

  // Number of set bits of vec strictly below position pos.
  function automatic int unsigned count_before(input logic [31:0] vec, input int unsigned pos);
    int unsigned n;
    n = 0;
    for (int unsigned k = 0; k < 32; k++) begin
      if (k < pos && vec[k]) n++;
    end
    return n;
  endfunction

  // Position of the nth set bit of vec (nth counted from 0); 0 when absent.
  function automatic int unsigned nth_set(input logic [63:0] vec, input int unsigned nth);
    int unsigned seen;
    int unsigned pos;
    logic        found;
    seen  = 0;
    pos   = 0;
    found = 1'b0;
    for (int unsigned k = 0; k < 64; k++) begin
      if (vec[k] && !found) begin
        if (seen == nth) begin
          pos   = k;
          found = 1'b1;
        end
        seen++;
      end
    end
    return pos;
  endfunction

endpackage

// File: rtl/ptwf_cam.sv
module ptwf_cam #(
  parameter int DEPTH = 8,
  parameter int VPN_W = 27
) (
  input  logic [VPN_W-1:0]       key,
  input  logic [DEPTH-1:0]       live,
  input  logic [DEPTH*VPN_W-1:0] tags,
  output logic [DEPTH-1:0]       hit_vec
);

  for (genvar e = 0; e < DEPTH; e++) begin : g_cmp
    assign hit_vec[e] = live[e] && (tags[e*VPN_W +: VPN_W] == key);
  end

endmodule

// File: rtl/ptwf_alloc.sv
module ptwf_alloc
  import ptwf_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 8,
  parameter int VPN_W  = 27,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CH_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic [NUM_CH-1:0]       req_valid,
  input  logic [NUM_CH*VPN_W-1:0] req_vpn,
  input  logic [NUM_CH-1:0]       hit_entry,
  input  logic [NUM_CH-1:0]       hit_rsp,
  input  logic [DEPTH-1:0]        ent_valid,
  output logic [NUM_CH-1:0]       req_ready,
  output logic [NUM_CH-1:0]       alloc,
  output logic [NUM_CH*IDX_W-1:0] alloc_idx,
  output logic [DEPTH-1:0]        alloc_vec
);

  logic [NUM_CH-1:0] dup_prev;
  logic [CH_W-1:0]   dup_src [NUM_CH];
  logic [NUM_CH-1:0] need_alloc;
  logic [NUM_CH-1:0] ready_base;
  int unsigned       free_cnt;

  // Earliest lower channel carrying the same VPN this cycle.
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      dup_prev[c] = 1'b0;
      dup_src[c]  = '0;
      for (int j = 0; j < c; j++) begin
        if (!dup_prev[c] && req_valid[j] &&
            req_vpn[j*VPN_W +: VPN_W] == req_vpn[c*VPN_W +: VPN_W]) begin
          dup_prev[c] = 1'b1;
          dup_src[c]  = CH_W'(j);
        end
      end
    end
  end

  assign need_alloc = req_valid & ~hit_entry & ~hit_rsp & ~dup_prev;
  assign free_cnt   = $countones(~ent_valid);

  // Channels needing a slot take free entries lowest-first, in channel order.
  always_comb begin
    alloc     = '0;
    alloc_idx = '0;
    alloc_vec = '0;
    for (int c = 0; c < NUM_CH; c++) begin
      int unsigned rank;
      rank = count_before(32'(need_alloc), c);
      alloc_idx[c*IDX_W +: IDX_W] = IDX_W'(nth_set(64'(~ent_valid), rank));
      alloc[c] = need_alloc[c] && (rank < free_cnt);
      if (alloc[c]) alloc_vec[alloc_idx[c*IDX_W +: IDX_W]] = 1'b1;
    end
  end

  assign ready_base = ~(need_alloc & ~alloc);

  // A same-cycle duplicate shares the fate of the channel it copies.
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      req_ready[c] = dup_prev[c] ? ready_base[dup_src[c]] : ready_base[c];
    end
  end

endmodule

// File: rtl/ptwf_order_q.sv
module ptwf_order_q
  import ptwf_pkg::*;
#(
  parameter int DEPTH  = 8,
  parameter int NUM_CH = 2,
  localparam int IDX_W = $clog2(DEPTH),
  localparam int CNT_W = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       push,
  input  logic [NUM_CH*IDX_W-1:0] push_idx,
  input  logic                    pop,
  output logic [IDX_W-1:0]        head_idx,
  output logic                    not_empty
);

  logic [IDX_W-1:0] slots [DEPTH];
  logic [IDX_W-1:0] rd_ptr;
  logic [CNT_W-1:0] cnt;
  logic [IDX_W-1:0] wpos [NUM_CH];
  int unsigned      npush;

  // Pushes of one cycle land in consecutive slots, in channel order.
  always_comb begin
    for (int c = 0; c < NUM_CH; c++) begin
      wpos[c] = IDX_W'(32'(rd_ptr) + 32'(cnt) + count_before(32'(push), c));
    end
  end

  assign npush     = $countones(push);
  assign head_idx  = slots[rd_ptr];
  assign not_empty = (cnt != '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_ptr <= '0;
      cnt    <= '0;
    end else begin
      if (pop) rd_ptr <= rd_ptr + 1'b1;
      cnt <= cnt + CNT_W'(npush) - CNT_W'(pop);
    end
  end

  always_ff @(posedge clk) begin
    for (int c = 0; c < NUM_CH; c++) begin
      if (push[c]) slots[wpos[c]] <= push_idx[c*IDX_W +: IDX_W];
    end
  end

endmodule

// File: rtl/ptw_merge_filter.sv
module ptw_merge_filter #(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 8,   // power of two, at most 64
  parameter int VPN_W  = 27,
  parameter int PPN_W  = 24,
  parameter int PERM_W = 8,
  parameter int LVL_W  = 2,
  localparam int IDX_W = $clog2(DEPTH)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic [NUM_CH-1:0]       req_valid,
  input  logic [NUM_CH*VPN_W-1:0] req_vpn,
  output logic [NUM_CH-1:0]       req_ready,
  output logic                    dn_req_valid,
  output logic [VPN_W-1:0]        dn_req_vpn,
  input  logic                    dn_req_ready,
  input  logic                    dn_rsp_valid,
  output logic                    dn_rsp_ready,
  input  logic [VPN_W-1:0]        dn_rsp_vpn,
  input  logic [PPN_W-1:0]        dn_rsp_ppn,
  input  logic [PERM_W-1:0]       dn_rsp_perm,
  input  logic [LVL_W-1:0]        dn_rsp_level,
  input  logic                    dn_rsp_fault,
  output logic                    up_rsp_valid,
  input  logic                    up_rsp_ready,
  output logic [VPN_W-1:0]        up_rsp_vpn,
  output logic [PPN_W-1:0]        up_rsp_ppn,
  output logic [PERM_W-1:0]       up_rsp_perm,
  output logic [LVL_W-1:0]        up_rsp_level,
  output logic                    up_rsp_fault
);

  // Entry table
  logic [DEPTH-1:0]       ent_valid;
  logic [DEPTH-1:0]       ent_issued;
  logic [DEPTH*VPN_W-1:0] ent_vpn;

  // Named events for the checker
  logic                    rsp_fire;
  logic                    issue_fire;
  logic [DEPTH-1:0]        rsp_hit_vec;
  logic [DEPTH-1:0]        release_vec;
  logic [NUM_CH-1:0]       hit_entry;
  logic [NUM_CH-1:0]       hit_rsp;
  logic [NUM_CH-1:0]       alloc;
  logic [NUM_CH*IDX_W-1:0] alloc_idx;
  logic [DEPTH-1:0]        alloc_vec;
  logic [IDX_W-1:0]        head_idx;
  logic                    q_not_empty;

  // Response path: straight through
  assign up_rsp_valid = dn_rsp_valid;
  assign dn_rsp_ready = up_rsp_ready;
  assign up_rsp_vpn   = dn_rsp_vpn;
  assign up_rsp_ppn   = dn_rsp_ppn;
  assign up_rsp_perm  = dn_rsp_perm;
  assign up_rsp_level = dn_rsp_level;
  assign up_rsp_fault = dn_rsp_fault;

  assign rsp_fire   = dn_rsp_valid && up_rsp_ready;
  assign issue_fire = dn_req_valid && dn_req_ready;

  ptwf_cam #(.DEPTH(DEPTH), .VPN_W(VPN_W)) u_rsp_cam (
    .key     (dn_rsp_vpn),
    .live    (ent_valid & ent_issued),
    .tags    (ent_vpn),
    .hit_vec (rsp_hit_vec)
  );
  assign release_vec = rsp_fire ? rsp_hit_vec : '0;

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [DEPTH-1:0] ch_hit_vec;
    ptwf_cam #(.DEPTH(DEPTH), .VPN_W(VPN_W)) u_req_cam (
      .key     (req_vpn[c*VPN_W +: VPN_W]),
      .live    (ent_valid),
      .tags    (ent_vpn),
      .hit_vec (ch_hit_vec)
    );
    assign hit_entry[c] = |ch_hit_vec;
    assign hit_rsp[c]   = rsp_fire && (dn_rsp_vpn == req_vpn[c*VPN_W +: VPN_W]);
  end

  ptwf_alloc #(.NUM_CH(NUM_CH), .DEPTH(DEPTH), .VPN_W(VPN_W)) u_alloc (
    .req_valid (req_valid),
    .req_vpn   (req_vpn),
    .hit_entry (hit_entry),
    .hit_rsp   (hit_rsp),
    .ent_valid (ent_valid),
    .req_ready (req_ready),
    .alloc     (alloc),
    .alloc_idx (alloc_idx),
    .alloc_vec (alloc_vec)
  );

  ptwf_order_q #(.DEPTH(DEPTH), .NUM_CH(NUM_CH)) u_order (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (alloc),
    .push_idx  (alloc_idx),
    .pop       (issue_fire),
    .head_idx  (head_idx),
    .not_empty (q_not_empty)
  );

  assign dn_req_valid = q_not_empty;
  assign dn_req_vpn   = ent_vpn[head_idx*VPN_W +: VPN_W];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_valid  <= '0;
      ent_issued <= '0;
    end else begin
      for (int e = 0; e < DEPTH; e++) begin
        if (release_vec[e]) begin
          ent_valid[e]  <= 1'b0;
          ent_issued[e] <= 1'b0;
        end else if (alloc_vec[e]) begin
          ent_valid[e]  <= 1'b1;
          ent_issued[e] <= 1'b0;
        end else if (issue_fire && head_idx == IDX_W'(e)) begin
          ent_issued[e] <= 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    for (int e = 0; e < DEPTH; e++) begin
      for (int c = 0; c < NUM_CH; c++) begin
        if (alloc[c] && alloc_idx[c*IDX_W +: IDX_W] == IDX_W'(e))
          ent_vpn[e*VPN_W +: VPN_W] <= req_vpn[c*VPN_W +: VPN_W];
      end
    end
  end

endmodule

// File: rtl/ptw_merge_filter_chk.sv
module ptw_merge_filter_chk #(
  parameter int NUM_CH = 2,
  parameter int DEPTH  = 8,
  parameter int VPN_W  = 27
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic [NUM_CH-1:0]       req_valid,
  input logic [NUM_CH*VPN_W-1:0] req_vpn,
  input logic [NUM_CH-1:0]       req_ready,
  input logic                    dn_req_valid,
  input logic                    dn_req_ready,
  input logic [VPN_W-1:0]        dn_req_vpn,
  input logic                    dn_rsp_valid,
  input logic [VPN_W-1:0]        dn_rsp_vpn,
  input logic                    up_rsp_ready,
  input logic [DEPTH-1:0]        ent_valid,
  input logic [NUM_CH-1:0]       alloc,
  input logic [DEPTH-1:0]        alloc_vec,
  input logic [DEPTH-1:0]        release_vec,
  input logic [NUM_CH-1:0]       hit_entry
);

  // R5
  dn_req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_req_valid && !dn_req_ready |=> dn_req_valid && $stable(dn_req_vpn));

  // R3
  same_cycle_dup_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[0] && req_valid[NUM_CH-1] &&
    req_vpn[0 +: VPN_W] == req_vpn[(NUM_CH-1)*VPN_W +: VPN_W]
    |-> $countones(alloc) <= 1);

  // R4
  merge_hit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid[0] && hit_entry[0] |-> req_ready[0] && !alloc[0]);

  // R8
  full_no_alloc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (&ent_valid) |-> alloc_vec == '0);

  // R10
  rsp_merge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    dn_rsp_valid && up_rsp_ready && req_valid[0] && req_vpn[0 +: VPN_W] == dn_rsp_vpn
    |-> req_ready[0] && !alloc[0]);

  // R7
  release_on_fire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_vec != '0 |-> dn_rsp_valid && up_rsp_ready);

  // R7
  release_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_vec != '0 |=> (ent_valid & $past(release_vec)) == '0);

endmodule

bind ptw_merge_filter ptw_merge_filter_chk #(
  .NUM_CH(NUM_CH), .DEPTH(DEPTH), .VPN_W(VPN_W)
) u_chk (.*);

// File: tb/ptw_merge_filter_tb.sv
module ptw_merge_filter_tb;

  localparam int NUM_CH = 2;
  localparam int DEPTH  = 8;
  localparam int VPN_W  = 12;
  localparam int PPN_W  = 10;
  localparam int PERM_W = 4;
  localparam int LVL_W  = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NUM_CH-1:0]       req_valid = '0;
  logic [NUM_CH*VPN_W-1:0] req_vpn = '0;
  logic [NUM_CH-1:0]       req_ready;
  logic                    dn_req_valid;
  logic [VPN_W-1:0]        dn_req_vpn;
  logic                    dn_req_ready = 1'b0;
  logic                    dn_rsp_valid = 1'b0;
  logic                    dn_rsp_ready;
  logic [VPN_W-1:0]        dn_rsp_vpn = '0;
  logic [PPN_W-1:0]        dn_rsp_ppn = '0;
  logic [PERM_W-1:0]       dn_rsp_perm = '0;
  logic [LVL_W-1:0]        dn_rsp_level = '0;
  logic                    dn_rsp_fault = 1'b0;
  logic                    up_rsp_valid;
  logic                    up_rsp_ready = 1'b0;
  logic [VPN_W-1:0]        up_rsp_vpn;
  logic [PPN_W-1:0]        up_rsp_ppn;
  logic [PERM_W-1:0]       up_rsp_perm;
  logic [LVL_W-1:0]        up_rsp_level;
  logic                    up_rsp_fault;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  ptw_merge_filter #(
    .NUM_CH(NUM_CH), .DEPTH(DEPTH), .VPN_W(VPN_W),
    .PPN_W(PPN_W), .PERM_W(PERM_W), .LVL_W(LVL_W)
  ) u_dut (.*);

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic set_req(input bit v0, input int a0, input bit v1, input int a1);
    req_valid = {v1, v0};
    req_vpn   = {VPN_W'(a1), VPN_W'(a0)};
  endtask

  task automatic set_rsp(input bit v, input int vpn, input bit up_rdy);
    dn_rsp_valid = v;
    dn_rsp_vpn   = VPN_W'(vpn);
    dn_rsp_ppn   = PPN_W'(vpn * 3 + 1);
    dn_rsp_perm  = PERM_W'(vpn);
    dn_rsp_level = LVL_W'(vpn >> 1);
    dn_rsp_fault = vpn[0];
    up_rsp_ready = up_rdy;
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    set_req(0, 0, 0, 0);
    set_rsp(0, 0, 0);
    dn_req_ready = 1'b0;
    tick();
    tick();
    rst_n = 1'b1;
    #1;
    check("R1 dn_req_valid after reset", dn_req_valid, 0);
    check("R1 req_ready after reset", req_ready, 2'b11);
    check("R1 up_rsp_valid after reset", up_rsp_valid, 0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin : main
    @(negedge clk);
    do_reset();

    // R2: two new VPNs in one cycle, channel 0 first
    set_req(1, 'h011, 1, 'h022);
    #1 check("R2 ready two new", req_ready, 2'b11);
    tick();
    set_req(0, 0, 0, 0);
    #1 check("R2 first issue valid", dn_req_valid, 1);
    check("R2 first issue vpn", dn_req_vpn, 'h011);
    tick();
    #1 check("R5 held valid", dn_req_valid, 1);
    check("R5 held vpn", dn_req_vpn, 'h011);
    dn_req_ready = 1'b1;
    tick();
    #1 check("R2 second issue vpn", dn_req_vpn, 'h022);
    tick();
    #1 check("R2 queue drained", dn_req_valid, 0);
    dn_req_ready = 1'b0;

    // R4: both channels hit issued entries
    set_req(1, 'h011, 1, 'h022);
    #1 check("R4 ready on merge", req_ready, 2'b11);
    tick();
    set_req(0, 0, 0, 0);
    #1 check("R4 no new walk", dn_req_valid, 0);

    // R3: same new VPN on both channels
    set_req(1, 'h033, 1, 'h033);
    #1 check("R3 ready same-cycle dup", req_ready, 2'b11);
    tick();
    set_req(0, 0, 0, 0);
    #1 check("R3 one walk vpn", dn_req_vpn, 'h033);
    dn_req_ready = 1'b1;
    tick();
    #1 check("R3 only one walk", dn_req_valid, 0);
    dn_req_ready = 1'b0;

    // R6: response passes through while upstream stalls
    set_rsp(1, 'h022, 0);
    #1 check("R6 up valid", up_rsp_valid, 1);
    check("R6 dn ready follows up", dn_rsp_ready, 0);
    check("R6 vpn", up_rsp_vpn, 'h022);
    check("R6 ppn", up_rsp_ppn, ('h022 * 3 + 1) % (1 << PPN_W));
    check("R6 perm", up_rsp_perm, 'h022 % (1 << PERM_W));
    check("R6 level", up_rsp_level, ('h022 >> 1) % (1 << LVL_W));
    check("R6 fault", up_rsp_fault, 0);
    tick();
    // R10: request meets its own response
    set_rsp(1, 'h022, 1);
    set_req(0, 0, 1, 'h022);
    #1 check("R6 dn ready on accept", dn_rsp_ready, 1);
    check("R10 ready on response match", req_ready, 2'b11);
    tick();
    set_rsp(0, 0, 0);
    set_req(0, 0, 0, 0);
    #1 check("R10 no entry created", dn_req_valid, 0);
    // R7: slot freed, same VPN walks again
    set_req(1, 'h022, 0, 0);
    #1 check("R7 ready after release", req_ready, 2'b11);
    tick();
    set_req(0, 0, 0, 0);
    #1 check("R7 new walk valid", dn_req_valid, 1);
    check("R7 new walk vpn", dn_req_vpn, 'h022);

    // Occupancy sweep: R8, R9, R11, ordering R2
    for (int k = 0; k <= DEPTH; k++) begin
      int exp_list [DEPTH + 2];
      int exp_n;
      int got;
      do_reset();
      for (int i = 0; i < k; i++) begin
        set_req(1, 'h100 + i, 0, 0);
        tick();
      end
      set_req(1, 'h200, 1, 'h201);
      #1 check($sformatf("R8 ch0 ready at fill %0d", k), req_ready[0], (k < DEPTH) ? 1 : 0);
      check($sformatf("R9 ch1 ready at fill %0d", k), req_ready[1], (k < DEPTH - 1) ? 1 : 0);
      tick();
      if (k > 0) begin
        set_req(0, 0, 1, 'h100);
        #1 check($sformatf("R8 dup accepted at fill %0d", k), req_ready[1], 1);
        tick();
      end
      set_req(0, 0, 0, 0);
      exp_n = 0;
      for (int i = 0; i < k; i++) begin
        exp_list[exp_n] = 'h100 + i;
        exp_n++;
      end
      if (k < DEPTH) begin
        exp_list[exp_n] = 'h200;
        exp_n++;
      end
      if (k < DEPTH - 1) begin
        exp_list[exp_n] = 'h201;
        exp_n++;
      end
      dn_req_ready = 1'b1;
      got = 0;
      for (int n = 0; n < DEPTH + 4; n++) begin
        #1;
        if (!dn_req_valid) break;
        if (got < exp_n)
          check($sformatf("R2 issue order fill %0d pos %0d", k, got), dn_req_vpn, exp_list[got]);
        got++;
        tick();
      end
      check($sformatf("R11 walks issued at fill %0d", k), got, exp_n);
      dn_req_ready = 1'b0;
      if (k == DEPTH) begin
        set_rsp(1, 'h100, 1);
        tick();
        set_rsp(0, 0, 0);
        set_req(1, 'h300, 1, 'h301);
        #1 check("R7 freed slot reused, R9 one slot", req_ready, 2'b01);
        tick();
        set_req(0, 0, 0, 0);
        #1 check("R7 reuse walk vpn", dn_req_vpn, 'h300);
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule